// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Address Decode

This block is a bus slave that sits between a processor's memory bus and two targets: a RAM port and an asynchronous serial port. Each request on the bus uses a valid/ready handshake. The block decodes the request address. Requests in the low 256 MiB region go to the RAM port unchanged, and the RAM's ready and read data come back to the processor. Two fixed peripheral addresses reach the serial port. All other addresses are acknowledged at once, return zero and have no effect.

The serial port uses the 8N1 format at a fixed 115200 baud: one start bit, 8 data bits with the least significant bit first, no parity and one stop bit. The line idles high. The transmitter counts 16 oversample ticks per bit. The receiver oversamples the line at 16 times the baud rate. It confirms a start bit at the middle of the bit, then samples each following bit at its centre.

One address serves two purposes. A write to it sends a byte, and a read from it returns the most recently received byte. A second address returns a status word that holds the transmitter-busy flag and the data-available flag.

Top module: `uart_mmio_slave`

## Requirements
- R1: Any address from 0x00000000 to 0x0FFFFFFF is passed to the RAM port with the same address, write enable and write data. The RAM's ready and read data are returned to the bus. No other address ever raises `ram_valid`.
- R2: A write to 0x10000000 while the transmitter is idle sends bits [7:0] of the write data. The frame is a low start bit, then data bits 0 to 7, then a high stop bit. Each bit lasts 16 × (CLK_HZ / (BAUD × 16)) clock cycles. The line starts low in the cycle after the write is accepted, and it stays high whenever no frame is being sent.
- R3: Status bit 0 (address 0x10000004) reads 1 from the cycle after an accepted transmit write until the stop bit has completed, and reads 0 otherwise.
- R4: A write to 0x10000000 while the transmitter is busy is ignored. The frame in progress continues unchanged.
- R5: After a received frame with a high stop bit, status bit 1 reads 1. A read of 0x10000000 then returns the byte in bits [7:0], with bits [31:8] zero.
- R6: A read of 0x10000000 clears status bit 1, unless a new byte arrives in the same cycle.
- R7: A frame whose stop bit is sampled low is dropped. The data-available flag and the held byte keep their values, and the receiver waits for the line to go high before it looks for a new start bit.
- R8: A low pulse shorter than half a bit period is not treated as a start bit, and no byte is delivered.
- R9: Status bits [31:2] read as zero. Addresses from 0x10000000 upward other than the two register addresses read as zero, and writes to them do nothing.
- R10: Every access outside the RAM region completes in the cycle it is presented, with `bus_ready` high.
- R11: A byte that arrives before the previous one has been read replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus request valid |
| bus_ready | output | 1 | Bus request accepted / read data valid |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| ram_valid | output | 1 | Request to RAM |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 32 | RAM address |
| ram_wdata | output | 32 | RAM write data |
| ram_ready | input | 1 | RAM accepted / read data valid |
| ram_rdata | input | 32 | RAM read data |
| uart_tx | output | 1 | Serial transmit line |
| uart_rx | input | 1 | Serial receive line |

## Verification
The embedded properties watch four things on every cycle. The line drops low exactly when the transmitter turns busy, and it stays high while the transmitter is idle. No start strobe reaches a busy transmitter. A delivered byte always follows a high stop-bit sample, and the data-available flag responds to a byte arriving and to a data read.

Some behaviour can only be shown by the bench's scenarios. These include the exact bit timing and order of a transmitted frame, which the bench compares against a behavioural model every clock. They also include recovery of looped-back bytes, rejection of glitches and of frames with a low stop bit, overwriting of an unread byte, and the boundary at the top of the RAM region.

// File: rtl/uart_mmio_pkg.sv
package uart_mmio_pkg;
   localparam int unsigned ADDR_W = 32;
   localparam logic [ADDR_W-1:0] SER_DATA_ADDR = 32'h1000_0000;
   localparam logic [ADDR_W-1:0] SER_STAT_ADDR = 32'h1000_0004;
   localparam int unsigned STAT_BUSY_BIT  = 0;
   localparam int unsigned STAT_AVAIL_BIT = 1;
   localparam int unsigned CHAR_W = 8;

   typedef enum logic [2:0] {
      RXS_IDLE,
      RXS_START,
      RXS_DATA,
      RXS_STOP,
      RXS_WAIT_HIGH
   } rx_state_t;
endpackage

// File: rtl/mmio_decode.sv
module mmio_decode
   import uart_mmio_pkg::*;
(
   input  logic [ADDR_W-1:0] addr,
   output logic              sel_ram,
   output logic              sel_data,
   output logic              sel_stat
);
   always_comb begin
      sel_ram  = (addr[ADDR_W-1:28] == '0);
      sel_data = (addr == SER_DATA_ADDR);
      sel_stat = (addr == SER_STAT_ADDR);
   end
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core #(
   parameter int unsigned DIV = 54,
   parameter int unsigned OVS = 16,
   parameter int unsigned CW  = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic [CW-1:0] data,
   output logic          busy,
   output logic          line
);
   localparam int unsigned BITS = CW + 2;
   localparam int unsigned DIVW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam int unsigned SUBW = $clog2(OVS);
   localparam int unsigned NBW  = $clog2(BITS);
   localparam logic [DIVW-1:0] DIV_LAST = DIVW'(DIV - 1);
   localparam logic [SUBW-1:0] SUB_LAST = SUBW'(OVS - 1);
   localparam logic [NBW-1:0]  NB_LAST  = NBW'(BITS - 1);

   logic [BITS-1:0] shreg;
   logic [DIVW-1:0] div_q;
   logic [SUBW-1:0] sub_q;
   logic [NBW-1:0]  nb_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy  <= 1'b0;
         shreg <= '1;
         div_q <= '0;
         sub_q <= '0;
         nb_q  <= '0;
      end else if (!busy) begin
         if (start) begin
            shreg <= {1'b1, data, 1'b0};
            busy  <= 1'b1;
            div_q <= '0;
            sub_q <= '0;
            nb_q  <= '0;
         end
      end else if (div_q == DIV_LAST) begin
         div_q <= '0;
         if (sub_q == SUB_LAST) begin
            sub_q <= '0;
            shreg <= {1'b1, shreg[BITS-1:1]};
            if (nb_q == NB_LAST) begin
               busy <= 1'b0;
               nb_q <= '0;
            end else begin
               nb_q <= nb_q + 1'b1;
            end
         end else begin
            sub_q <= sub_q + 1'b1;
         end
      end else begin
         div_q <= div_q + 1'b1;
      end
   end

   assign line = shreg[0];

   p_start_idle_r4: assert property (@(posedge clk) disable iff (rst)
      start |-> !busy);
   p_line_start_r2: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> !line);
   p_idle_high_r2: assert property (@(posedge clk) disable iff (rst)
      !busy |-> line);
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
   import uart_mmio_pkg::*;
#(
   parameter int unsigned DIV  = 54,
   parameter int unsigned OVS  = 16,
   parameter int unsigned CW   = 8,
   parameter int unsigned SYNC = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          line,
   output logic          valid,
   output logic [CW-1:0] data
);
   localparam int unsigned DIVW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam int unsigned SUBW = $clog2(OVS);
   localparam int unsigned NBW  = (CW > 1) ? $clog2(CW) : 1;
   localparam logic [DIVW-1:0] DIV_LAST = DIVW'(DIV - 1);
   localparam logic [SUBW-1:0] SUB_LAST = SUBW'(OVS - 1);
   localparam logic [SUBW-1:0] SUB_HALF = SUBW'(OVS / 2 - 1);
   localparam logic [NBW-1:0]  NB_LAST  = NBW'(CW - 1);

   logic [SYNC-1:0] sync_q;
   generate
      if (SYNC == 1) begin : g_sync_one
         always_ff @(posedge clk) begin
            if (rst) sync_q <= '1;
            else     sync_q <= line;
         end
      end else begin : g_sync_chain
         always_ff @(posedge clk) begin
            if (rst) sync_q <= '1;
            else     sync_q <= {sync_q[SYNC-2:0], line};
         end
      end
   endgenerate

   logic line_s;
   assign line_s = sync_q[SYNC-1];

   rx_state_t       st;
   logic [DIVW-1:0] div_q;
   logic [SUBW-1:0] sub_q;
   logic [NBW-1:0]  nb_q;
   logic [CW-1:0]   shreg;
   logic            tick;

   assign tick = (div_q == DIV_LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         st    <= RXS_IDLE;
         div_q <= '0;
         sub_q <= '0;
         nb_q  <= '0;
         shreg <= '0;
         data  <= '0;
         valid <= 1'b0;
      end else begin
         valid <= 1'b0;
         div_q <= tick ? '0 : div_q + 1'b1;
         unique case (st)
            RXS_IDLE: begin
               div_q <= '0;
               sub_q <= '0;
               if (!line_s) st <= RXS_START;
            end
            RXS_START: if (tick) begin
               if (sub_q == SUB_HALF) begin
                  sub_q <= '0;
                  nb_q  <= '0;
                  st    <= line_s ? RXS_IDLE : RXS_DATA;
               end else begin
                  sub_q <= sub_q + 1'b1;
               end
            end
            RXS_DATA: if (tick) begin
               if (sub_q == SUB_LAST) begin
                  sub_q <= '0;
                  shreg <= {line_s, shreg[CW-1:1]};
                  if (nb_q == NB_LAST) st <= RXS_STOP;
                  else                 nb_q <= nb_q + 1'b1;
               end else begin
                  sub_q <= sub_q + 1'b1;
               end
            end
            RXS_STOP: if (tick) begin
               if (sub_q == SUB_LAST) begin
                  sub_q <= '0;
                  if (line_s) begin
                     valid <= 1'b1;
                     data  <= shreg;
                     st    <= RXS_IDLE;
                  end else begin
                     st <= RXS_WAIT_HIGH;
                  end
               end else begin
                  sub_q <= sub_q + 1'b1;
               end
            end
            RXS_WAIT_HIGH: if (line_s) st <= RXS_IDLE;
            default: st <= RXS_IDLE;
         endcase
      end
   end

   p_stop_high_r7: assert property (@(posedge clk) disable iff (rst)
      valid |-> $past(line_s));
endmodule

// File: rtl/uart_mmio_slave.sv
module uart_mmio_slave
   import uart_mmio_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 100_000_000,
   parameter int unsigned BAUD        = 115_200,
   parameter int unsigned OVS         = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DW          = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_valid,
   output logic              bus_ready,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   output logic              ram_valid,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [DW-1:0]     ram_wdata,
   input  logic              ram_ready,
   input  logic [DW-1:0]     ram_rdata,
   output logic              uart_tx,
   input  logic              uart_rx
);
   localparam int unsigned DIV = CLK_HZ / (BAUD * OVS);

   generate
      if (DIV < 2) begin : g_bad_div
         $error("clock too slow for the requested baud and oversampling");
      end
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("oversampling factor must be even and at least 4");
      end
      if (DW < CHAR_W || SYNC_STAGES < 1) begin : g_bad_width
         $error("data width or synchronizer depth out of range");
      end
   endgenerate

   logic sel_ram, sel_data, sel_stat;
   mmio_decode u_dec (
      .addr    (bus_addr),
      .sel_ram (sel_ram),
      .sel_data(sel_data),
      .sel_stat(sel_stat)
   );

   logic              tx_busy, tx_start;
   logic              rx_valid;
   logic [CHAR_W-1:0] rx_data;
   logic [CHAR_W-1:0] held_byte;
   logic              avail;
   logic              hs, rd_data;

   always_comb begin
      ram_valid = bus_valid & sel_ram;
      ram_we    = bus_we;
      ram_addr  = bus_addr;
      ram_wdata = bus_wdata;
      bus_ready = sel_ram ? ram_ready : bus_valid;
      if (sel_ram)       bus_rdata = ram_rdata;
      else if (sel_data) bus_rdata = {{(DW-CHAR_W){1'b0}}, held_byte};
      else if (sel_stat) bus_rdata = {{(DW-2){1'b0}}, avail, tx_busy};
      else               bus_rdata = '0;
   end

   assign hs       = bus_valid & bus_ready;
   assign tx_start = hs & bus_we & sel_data & ~tx_busy;
   assign rd_data  = hs & ~bus_we & sel_data;

   always_ff @(posedge clk) begin
      if (rst) begin
         avail     <= 1'b0;
         held_byte <= '0;
      end else if (rx_valid) begin
         avail     <= 1'b1;
         held_byte <= rx_data;
      end else if (rd_data) begin
         avail <= 1'b0;
      end
   end

   uart_tx_core #(.DIV(DIV), .OVS(OVS), .CW(CHAR_W)) u_tx (
      .clk  (clk),
      .rst  (rst),
      .start(tx_start),
      .data (bus_wdata[CHAR_W-1:0]),
      .busy (tx_busy),
      .line (uart_tx)
   );

   uart_rx_core #(.DIV(DIV), .OVS(OVS), .CW(CHAR_W), .SYNC(SYNC_STAGES)) u_rx (
      .clk  (clk),
      .rst  (rst),
      .line (uart_rx),
      .valid(rx_valid),
      .data (rx_data)
   );

   p_avail_set_r5: assert property (@(posedge clk) disable iff (rst)
      rx_valid |=> avail);
   p_rd_clears_r6: assert property (@(posedge clk) disable iff (rst)
      (rd_data && !rx_valid) |=> !avail);
endmodule

// File: tb/uart_mmio_slave_tb.sv
module uart_mmio_slave_tb;
   localparam int unsigned CLK_HZ = 7_372_800;
   localparam int unsigned BAUD   = 115_200;
   localparam int unsigned DIVB   = CLK_HZ / (BAUD * 16);
   localparam int unsigned BIT    = 16 * DIVB;
   localparam int unsigned FRAME  = 10 * BIT;
   localparam logic [31:0] A_DATA = 32'h1000_0000;
   localparam logic [31:0] A_STAT = 32'h1000_0004;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bus_valid = 1'b0, bus_we = 1'b0;
   logic [31:0] bus_addr = '0, bus_wdata = '0;
   logic        bus_ready;
   logic [31:0] bus_rdata;
   logic        ram_valid, ram_we, ram_ready;
   logic [31:0] ram_addr, ram_wdata, ram_rdata;
   logic        uart_tx, uart_rx;
   logic        loop = 1'b0, rx_drive = 1'b1;
   logic [31:0] ram_mem [0:15];

   int checks = 0, errors = 0;

   always #5 clk = ~clk;

   assign uart_rx   = loop ? uart_tx : rx_drive;
   assign ram_ready = ram_valid;
   assign ram_rdata = ram_mem[ram_addr[5:2]];
   always @(posedge clk) if (ram_valid && ram_we) ram_mem[ram_addr[5:2]] <= ram_wdata;

   uart_mmio_slave #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_dut (
      .clk(clk), .rst(rst),
      .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ram_valid(ram_valid), .ram_we(ram_we), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata), .ram_ready(ram_ready), .ram_rdata(ram_rdata),
      .uart_tx(uart_tx), .uart_rx(uart_rx)
   );

   // behavioural model of the transmit line
   bit       m_busy = 0;
   int       m_cnt  = 0;
   bit [7:0] m_byte = '0;
   always @(posedge clk) begin
      if (rst) begin
         m_busy = 0; m_cnt = 0;
      end else if (m_busy) begin
         m_cnt++;
         if (m_cnt == FRAME) m_busy = 0;
      end else if (bus_valid && bus_we && bus_addr == A_DATA) begin
         m_busy = 1; m_cnt = 0; m_byte = bus_wdata[7:0];
      end
   end

   function automatic logic exp_tx();
      int idx;
      if (!m_busy) return 1'b1;
      idx = m_cnt / BIT;
      if (idx == 0) return 1'b0;
      if (idx == 9) return 1'b1;
      return m_byte[idx-1];
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   always @(negedge clk) if (!rst) chk("R2 tx line vs model", {31'b0, uart_tx}, {31'b0, exp_tx()});

   task automatic xfer(input logic we, input logic [31:0] a, input logic [31:0] d,
                       output logic [31:0] q, output logic rv, output logic rdy);
      int w;
      @(negedge clk);
      bus_valid = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
      #1;
      rv = ram_valid; rdy = bus_ready;
      w = 0;
      while (!bus_ready && w < 100) begin @(negedge clk); #1; w++; end
      q = bus_rdata;
      @(posedge clk); #1;
      bus_valid = 1'b0; bus_we = 1'b0;
   endtask

   task automatic send_frame(input logic [7:0] b, input logic stop);
      logic [9:0] f;
      f = {stop, b, 1'b0};
      for (int i = 0; i < 10; i++) begin
         @(negedge clk); rx_drive = f[i];
         repeat (BIT - 1) @(negedge clk);
      end
      @(negedge clk); rx_drive = 1'b1;
      repeat (BIT) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] q;
      logic rv, rdy;
      repeat (5) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R9 reset status", 32'(uart_tx), 32'd1);
      xfer(0, A_STAT, 0, q, rv, rdy);
      chk("R3 reset status zero", q, 32'h0);
      chk("R10 status ready same cycle", {31'b0, rdy}, 32'd1);

      // R1 RAM forwarding and region boundary
      xfer(1, 32'h0000_0010, 32'hDEAD_BEEF, q, rv, rdy);
      chk("R1 ram_valid on low write", {31'b0, rv}, 32'd1);
      xfer(0, 32'h0000_0010, 0, q, rv, rdy);
      chk("R1 ram read back", q, 32'hDEAD_BEEF);
      xfer(1, 32'h0FFF_FFFC, 32'h1234_5678, q, rv, rdy);
      xfer(0, 32'h0FFF_FFFC, 0, q, rv, rdy);
      chk("R1 top of ram region", q, 32'h1234_5678);
      xfer(0, A_STAT, 0, q, rv, rdy);
      chk("R1 no ram_valid for status", {31'b0, rv}, 32'd0);

      // R9 unmapped peripheral addresses
      xfer(1, 32'h1000_0008, 32'hFFFF_FFFF, q, rv, rdy);
      xfer(0, 32'h1000_0008, 0, q, rv, rdy);
      chk("R9 unmapped reads zero", q, 32'h0);
      chk("R10 unmapped ready", {31'b0, rdy}, 32'd1);
      chk("R1 no ram_valid for unmapped", {31'b0, rv}, 32'd0);

      // R5 / R6 receive path
      send_frame(8'hA5, 1'b1);
      xfer(0, A_STAT, 0, q, rv, rdy);
      chk("R5 avail set", q, 32'h2);
      xfer(0, A_DATA, 0, q, rv, rdy);
      chk("R5 received byte", q, 32'h0000_00A5);
      xfer(0, A_STAT, 0, q, rv, rdy);
      chk("R6 avail cleared by read", q, 32'h0);

      // R11 overwrite unread byte
      send_frame(8'h3C, 1'b1);
      send_frame(8'hC3, 1'b1);
      xfer(0, A_DATA, 0, q, rv, rdy);
      chk("R11 newest byte kept", q, 32'h0000_00C3);

      // R7 low stop bit dropped
      send_frame(8'h55, 1'b0);
      xfer(0, A_STAT, 0, q, rv, rdy);
      chk("R7 bad frame no avail", q, 32'h0);
      xfer(0, A_DATA, 0, q, rv, rdy);
      chk("R7 held byte unchanged", q, 32'h0000_00C3);

      // R8 short glitch
      @(negedge clk); rx_drive = 1'b0;
      repeat (BIT / 4) @(negedge clk);
      rx_drive = 1'b1;
      repeat (FRAME) @(negedge clk);
      xfer(0, A_STAT, 0, q, rv, rdy);
      chk("R8 glitch ignored", q, 32'h0);
      send_frame(8'h5A, 1'b1);
      xfer(0, A_DATA, 0, q, rv, rdy);
      chk("R8 receiver still works", q, 32'h0000_005A);

      // R2 / R3 / R4 transmit with loopback
      loop = 1'b1;
      repeat (4) @(negedge clk);
      xfer(1, A_DATA, 32'h1234_5666, q, rv, rdy);
      xfer(0, A_STAT, 0, q, rv, rdy);
      chk("R3 busy after write", q, 32'h1);
      xfer(1, A_DATA, 32'h0000_0099, q, rv, rdy);
      repeat (FRAME + BIT) @(negedge clk);
      xfer(0, A_STAT, 0, q, rv, rdy);
      chk("R3 busy clear, byte looped back", q, 32'h2);
      xfer(0, A_DATA, 0, q, rv, rdy);
      chk("R4 write while busy ignored", q, 32'h0000_0066);

      xfer(1, A_DATA, 32'h0000_0081, q, rv, rdy);
      repeat (FRAME + BIT) @(negedge clk);
      xfer(0, A_DATA, 0, q, rv, rdy);
      chk("R2 second frame looped back", q, 32'h0000_0081);
      xfer(0, A_STAT, 0, q, rv, rdy);
      chk("R9 status upper bits zero", q, 32'h0);

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule